// File: doc/BRIEF.md
# Write-Leveling Strobe Feedback Responder

This block stands in for the memory-device half of write leveling on a single channel with two byte lanes. A controller levels its strobes by sending each strobe while the device samples the clock at the rising strobe edge. The device returns the sampled level on the data bits of that lane, and the controller moves its strobe delay until the feedback changes. The responder decodes mode-register writes to switch leveling on and off. While leveling is on, it keeps one captured clock level per lane. Every rising strobe edge of that lane overwrites the level, and the level is copied onto all eight data bits of the lane after a fixed number of clock cycles.

Commands come in already decoded. Each cycle carries a command kind, plus a register address and operand that matter only for mode-register writes. The clock level is given as one sampled bit, and each strobe rising edge arrives as a one-cycle pulse per lane. While leveling is on, only deselect and the write that turns leveling off are legal. Any other command sets a sticky error flag that only reset clears. The asynchronous reset is released through a two-stage synchronizer.

Top module: `wl_responder`

## Requirements
- R1: After reset, `dq` is all zeros, `err` is 0 and leveling is off.
- R2: `cmd_kind` encodes 2'b00 deselect, 2'b01 mode-register write, 2'b10 and 2'b11 other commands. A mode-register write to address 2 with operand bit 7 set turns leveling on. A write to address 2 with operand bit 7 clear turns it off. Writes to other addresses never change the mode. The new mode takes effect after the clock edge that samples the command.
- R3: When leveling is on and a lane's strobe pulse is sampled at edge n, that lane's data bits show the `ck_level` sampled at edge n from edge n+WLO_CYC onward (default WLO_CYC = 3).
- R4: All data bits of a lane carry the same value. Lane 0 drives `dq[7:0]` from `dqs_rise[0]`, and lane 1 drives `dq[15:8]` from `dqs_rise[1]`.
- R5: A strobe pulse on one lane never changes the other lane's data bits.
- R6: Each new strobe pulse overwrites the lane's previous capture, including pulses on consecutive cycles. The data bits follow the captures in order.
- R7: After leveling is turned on, a lane's data bits read 0 until its first capture arrives.
- R8: While leveling is off, `dq` reads all zeros and strobe pulses are ignored. A pulse sampled while leveling is off, or still in flight when leveling is turned off, never appears after leveling is turned on again.
- R9: While leveling is on, any command other than deselect or the leveling-off write sets `err` after the edge that samples it. This includes a write to address 2 with bit 7 set and a write to another address. No command sets `err` while leveling is off.
- R10: `err` stays set, through leveling exit and later commands, until reset. Illegal commands do not change the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_kind | input | 2 | Decoded command kind |
| cmd_addr | input | 6 | Mode-register address for a write |
| cmd_op | input | 8 | Mode-register operand for a write |
| ck_level | input | 1 | Clock level sampled at the strobe edge |
| dqs_rise | input | 2 | Per-lane strobe rising-edge pulse |
| dq | output | 16 | Feedback data bits, lane 1 in the upper byte |
| err | output | 1 | Sticky illegal-command flag |

## Verification
The hardest case to reach is a capture still inside the output delay when leveling is switched off. That capture has to vanish, so that re-entering the mode shows zeros and not the stale level. The stimulus fires a strobe pulse and then issues the leveling-off write on the very next cycle. It re-enters two cycles later and watches the data bits through the whole delay window. Back-to-back strobe pulses with alternating clock levels, and a strobe pulse in the same cycle as the entry write, cover the overwrite and edge-of-mode cases.

// File: rtl/wl_resp_pkg.sv
package wl_resp_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'b00,
    CMD_MRW   = 2'b01,
    CMD_OTH_A = 2'b10,
    CMD_OTH_B = 2'b11
  } cmd_kind_e;

  typedef struct packed {
    logic vld;
    logic lvl;
  } cap_t;

endpackage

// File: rtl/wl_rst_sync.sv
module wl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_n_out = sync_q[STAGES-1];

endmodule

// File: rtl/wl_cmd_decode.sv
module wl_cmd_decode
  import wl_resp_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int OP_W      = 8,
  parameter int LEVEL_MR  = 2,
  parameter int LEVEL_BIT = 7
) (
  input  logic [1:0]        cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [OP_W-1:0]   cmd_op,
  output logic              is_desel,
  output logic              is_enter,
  output logic              is_exit
);

  localparam logic [ADDR_W-1:0] MR_SEL = ADDR_W'(LEVEL_MR);

  logic is_mrw;
  logic hit_mr;

  always_comb begin
    is_mrw   = (cmd_kind_e'(cmd_kind) == CMD_MRW);
    hit_mr   = is_mrw && (cmd_addr == MR_SEL);
    is_desel = (cmd_kind_e'(cmd_kind) == CMD_DESEL);
    is_enter = hit_mr &&  cmd_op[LEVEL_BIT];
    is_exit  = hit_mr && !cmd_op[LEVEL_BIT];
  end

endmodule

// File: rtl/wl_mode_ctrl.sv
module wl_mode_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic is_desel,
  input  logic is_enter,
  input  logic is_exit,
  output logic level_mode,
  output logic err
);

  logic mode_q, mode_d;
  logic err_q, err_d;
  logic illegal;
  logic mode_en;
  logic err_en;

  always_comb begin
    illegal = mode_q && !is_desel && !is_exit;
    mode_en = (!mode_q && is_enter) || (mode_q && is_exit);
    mode_d  = mode_q;
    if (mode_en) begin
      mode_d = !mode_q;
    end
    err_en = illegal && !err_q;
    err_d  = err_q;
    if (err_en) begin
      err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (mode_en) begin
        mode_q <= mode_d;
      end
      if (err_en) begin
        err_q <= err_d;
      end
    end
  end

  assign level_mode = mode_q;
  assign err        = err_q;

endmodule

// File: rtl/wl_lane.sv
module wl_lane
  import wl_resp_pkg::*;
#(
  parameter int LANE_W  = 8,
  parameter int WLO_CYC = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              level_mode,
  input  logic              strobe_rise,
  input  logic              ck_level,
  output logic [LANE_W-1:0] dq_lane
);

  localparam int LAST = WLO_CYC - 1;

  cap_t pipe_q [WLO_CYC];
  cap_t pipe_d [WLO_CYC];
  logic out_q, out_d;
  logic out_en;

  // delay stages: stage 0 takes the fresh capture, later stages shift
  for (genvar g = 0; g < WLO_CYC; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb begin
        if (!level_mode) begin
          pipe_d[g] = '0;
        end else begin
          pipe_d[g] = '{vld: strobe_rise, lvl: ck_level};
        end
      end
    end else begin : g_body
      always_comb begin
        if (!level_mode) begin
          pipe_d[g] = '0;
        end else begin
          pipe_d[g] = pipe_q[g-1];
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pipe_q[g] <= '0;
      end else begin
        pipe_q[g] <= pipe_d[g];
      end
    end
  end

  always_comb begin
    out_en = !level_mode || pipe_q[LAST].vld;
    out_d  = level_mode ? pipe_q[LAST].lvl : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  assign dq_lane = level_mode ? {LANE_W{out_q}} : '0;

endmodule

// File: rtl/wl_responder.sv
module wl_responder
  import wl_resp_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int LANE_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int OP_W      = 8,
  parameter int LEVEL_MR  = 2,
  parameter int LEVEL_BIT = 7,
  parameter int WLO_CYC   = 3,
  parameter int SYNC_STG  = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               cmd_kind,
  input  logic [ADDR_W-1:0]        cmd_addr,
  input  logic [OP_W-1:0]          cmd_op,
  input  logic                     ck_level,
  input  logic [LANES-1:0]         dqs_rise,
  output logic [LANES*LANE_W-1:0]  dq,
  output logic                     err
);

  localparam int DQ_W = LANES * LANE_W;

  logic rst_ns;
  logic is_desel, is_enter, is_exit;
  logic level_mode;

  wl_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_ns)
  );

  wl_cmd_decode #(
    .ADDR_W    (ADDR_W),
    .OP_W      (OP_W),
    .LEVEL_MR  (LEVEL_MR),
    .LEVEL_BIT (LEVEL_BIT)
  ) u_dec (
    .cmd_kind (cmd_kind),
    .cmd_addr (cmd_addr),
    .cmd_op   (cmd_op),
    .is_desel (is_desel),
    .is_enter (is_enter),
    .is_exit  (is_exit)
  );

  wl_mode_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_ns),
    .is_desel   (is_desel),
    .is_enter   (is_enter),
    .is_exit    (is_exit),
    .level_mode (level_mode),
    .err        (err)
  );

  logic [DQ_W-1:0] dq_w;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    wl_lane #(
      .LANE_W  (LANE_W),
      .WLO_CYC (WLO_CYC)
    ) u_lane (
      .clk         (clk),
      .rst_n       (rst_ns),
      .level_mode  (level_mode),
      .strobe_rise (dqs_rise[l]),
      .ck_level    (ck_level),
      .dq_lane     (dq_w[l*LANE_W +: LANE_W])
    );
  end

  assign dq = dq_w;

endmodule

// File: rtl/wl_responder_chk.sv
module wl_responder_chk #(
  parameter int LANES     = 2,
  parameter int LANE_W    = 8,
  parameter int ADDR_W    = 6,
  parameter int OP_W      = 8,
  parameter int LEVEL_MR  = 2,
  parameter int LEVEL_BIT = 7
) (
  input logic                    clk,
  input logic                    rst_ns,
  input logic [1:0]              cmd_kind,
  input logic [ADDR_W-1:0]       cmd_addr,
  input logic [OP_W-1:0]         cmd_op,
  input logic [LANES*LANE_W-1:0] dq,
  input logic                    err,
  input logic                    level_mode
);

  logic c_enter, c_exit, c_bad;

  always_comb begin
    c_enter = (cmd_kind == 2'b01) && (cmd_addr == ADDR_W'(LEVEL_MR)) && cmd_op[LEVEL_BIT];
    c_exit  = (cmd_kind == 2'b01) && (cmd_addr == ADDR_W'(LEVEL_MR)) && !cmd_op[LEVEL_BIT];
    c_bad   = level_mode && (cmd_kind != 2'b00) && !c_exit;
  end

  assert_enter_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (!level_mode && c_enter) |=> level_mode);

  assert_exit_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (level_mode && c_exit) |=> !level_mode);

  assert_off_zero_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    !level_mode |-> (dq == '0));

  assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    c_bad |=> err);

  assert_no_false_flag_R9: assert property (@(posedge clk) disable iff (!rst_ns)
    (!err && !c_bad) |=> !err);

  assert_sticky_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    err |=> err);

  assert_mode_kept_R10: assert property (@(posedge clk) disable iff (!rst_ns)
    c_bad |=> level_mode);

  for (genvar l = 0; l < LANES; l++) begin : g_uni
    assert_lane_uniform_R4: assert property (@(posedge clk) disable iff (!rst_ns)
      ($countones(dq[l*LANE_W +: LANE_W]) == 0) ||
      ($countones(dq[l*LANE_W +: LANE_W]) == LANE_W));
  end

endmodule

bind wl_responder wl_responder_chk #(
  .LANES     (LANES),
  .LANE_W    (LANE_W),
  .ADDR_W    (ADDR_W),
  .OP_W      (OP_W),
  .LEVEL_MR  (LEVEL_MR),
  .LEVEL_BIT (LEVEL_BIT)
) u_chk (
  .clk        (clk),
  .rst_ns     (rst_ns),
  .cmd_kind   (cmd_kind),
  .cmd_addr   (cmd_addr),
  .cmd_op     (cmd_op),
  .dq         (dq),
  .err        (err),
  .level_mode (level_mode)
);

// File: tb/wl_responder_tb.sv
module wl_responder_tb;

  localparam int WLO = 3;
  localparam int NL  = 2;
  localparam int LW  = 8;

  logic        clk;
  logic        rst_n;
  logic [1:0]  cmd_kind;
  logic [5:0]  cmd_addr;
  logic [7:0]  cmd_op;
  logic        ck_level;
  logic [1:0]  dqs_rise;
  logic [15:0] dq;
  logic        err;

  int n_chk;
  int n_bad;
  bit done;

  // reference state built from the requirements
  bit m_mode, m_err;
  bit hv [NL][WLO];
  bit hl [NL][WLO];
  bit m_out [NL];

  logic [16:0] q_exp [$];
  string       q_tag [$];

  wl_responder #(.WLO_CYC(WLO)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_kind (cmd_kind),
    .cmd_addr (cmd_addr),
    .cmd_op   (cmd_op),
    .ck_level (ck_level),
    .dqs_rise (dqs_rise),
    .dq       (dq),
    .err      (err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic model_clear();
    m_mode = 0;
    m_err  = 0;
    for (int l = 0; l < NL; l++) begin
      m_out[l] = 0;
      for (int j = 0; j < WLO; j++) begin
        hv[l][j] = 0;
        hl[l][j] = 0;
      end
    end
  endtask

  task automatic step(input logic [1:0] k, input logic [5:0] a, input logic [7:0] o,
                      input bit ck, input logic [1:0] r, input string tag);
    bit bad, nm;
    logic [15:0] e;
    @(negedge clk);
    cmd_kind = k; cmd_addr = a; cmd_op = o; ck_level = ck; dqs_rise = r;
    bad = m_mode && (k != 2'b00) && !(k == 2'b01 && a == 6'd2 && !o[7]);
    for (int l = 0; l < NL; l++) begin
      if (!m_mode) begin
        m_out[l] = 0;
        for (int j = 0; j < WLO; j++) begin hv[l][j] = 0; hl[l][j] = 0; end
      end else begin
        if (hv[l][WLO-1]) m_out[l] = hl[l][WLO-1];
        for (int j = WLO-1; j > 0; j--) begin hv[l][j] = hv[l][j-1]; hl[l][j] = hl[l][j-1]; end
        hv[l][0] = r[l];
        hl[l][0] = ck;
      end
    end
    nm = m_mode;
    if (!m_mode && k == 2'b01 && a == 6'd2 && o[7]) nm = 1;
    else if (m_mode && k == 2'b01 && a == 6'd2 && !o[7]) nm = 0;
    m_mode = nm;
    m_err  = m_err | bad;
    for (int l = 0; l < NL; l++) e[l*LW +: LW] = m_mode ? {LW{m_out[l]}} : '0;
    q_exp.push_back({m_err, e});
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(2'b00, 6'd0, 8'd0, 1'b0, 2'b00, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    cmd_kind = 0; cmd_addr = 0; cmd_op = 0; ck_level = 0; dqs_rise = 0;
    model_clear();
    repeat (2) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    n_chk++;
    if (dq !== 16'h0 || err !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset state dq=%h err=%b expected dq=0000 err=0", dq, err);
    end
  endtask

  // monitor: compares after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q_exp.size() > 0) begin
        logic [16:0] x;
        string t;
        x = q_exp.pop_front();
        t = q_tag.pop_front();
        n_chk++;
        if (dq !== x[15:0] || err !== x[16]) begin
          n_bad++;
          $display("FAIL %s dq=%h err=%b expected dq=%h err=%b", t, dq, err, x[15:0], x[16]);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    rst_n = 0;
    do_reset();

    // R8: strobes while off are ignored; writes elsewhere do nothing (R2)
    step(2'b00, 6'd0, 8'd0, 1'b1, 2'b11, "R8");
    step(2'b01, 6'd1, 8'h80, 1'b1, 2'b11, "R2");
    step(2'b01, 6'd2, 8'h00, 1'b1, 2'b00, "R2");
    step(2'b10, 6'd0, 8'd0, 1'b0, 2'b00, "R9");
    idle(3, "R8");

    // R2 entry with a simultaneous strobe (must be ignored), then R7 zeros
    step(2'b01, 6'd2, 8'h80, 1'b1, 2'b11, "R2");
    idle(5, "R7");

    // R3 latency on lane 0
    step(2'b00, 6'd0, 8'd0, 1'b1, 2'b01, "R3");
    idle(5, "R3");

    // R5 independence: lane 1 captures 1 while lane 0 holds, then lane 0 captures 0
    step(2'b00, 6'd0, 8'd0, 1'b1, 2'b10, "R5");
    idle(4, "R4");
    step(2'b00, 6'd0, 8'd0, 1'b0, 2'b01, "R5");
    idle(4, "R5");

    // R6 back-to-back overwrites
    step(2'b00, 6'd0, 8'd0, 1'b1, 2'b01, "R6");
    step(2'b00, 6'd0, 8'd0, 1'b0, 2'b01, "R6");
    step(2'b00, 6'd0, 8'd0, 1'b1, 2'b11, "R6");
    step(2'b00, 6'd0, 8'd0, 1'b0, 2'b10, "R6");
    idle(5, "R6");

    // R8 capture in flight at exit, then re-entry shows zeros
    step(2'b00, 6'd0, 8'd0, 1'b0, 2'b11, "R8");
    step(2'b00, 6'd0, 8'd0, 1'b1, 2'b11, "R8");
    step(2'b01, 6'd2, 8'h7F, 1'b0, 2'b00, "R2");
    idle(2, "R8");
    step(2'b01, 6'd2, 8'hFF, 1'b0, 2'b00, "R2");
    idle(5, "R8");

    // R6 sweep of mixed patterns
    for (int i = 0; i < 40; i++)
      step(2'b00, 6'd0, 8'd0, bit'(((i * 5) % 3) == 0), 2'(i % 4), "R6");
    idle(4, "R6");

    // R9 other command kind during leveling; R10 sticky through exit
    step(2'b11, 6'd0, 8'd0, 1'b0, 2'b00, "R9");
    idle(3, "R10");
    step(2'b01, 6'd2, 8'h00, 1'b0, 2'b00, "R10");
    idle(4, "R10");

    // R9 write to MR2 with bit 7 set while on: flags, mode stays (R10)
    do_reset();
    step(2'b01, 6'd2, 8'h80, 1'b0, 2'b00, "R2");
    step(2'b00, 6'd0, 8'd0, 1'b1, 2'b01, "R3");
    step(2'b01, 6'd2, 8'h80, 1'b0, 2'b00, "R9");
    idle(5, "R10");

    // R9 write to another address while on
    do_reset();
    step(2'b01, 6'd2, 8'h80, 1'b0, 2'b00, "R2");
    idle(2, "R9");
    step(2'b01, 6'd5, 8'h00, 1'b0, 2'b00, "R9");
    idle(3, "R9");
    step(2'b01, 6'd2, 8'h00, 1'b0, 2'b00, "R10");
    idle(3, "R10");

    idle(2, "R1");
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule